// File: doc/BRIEF.md
# Point-addressed display panel controller

This block sits between a host and a matrix display whose cells are bistable: once a cell is lit or dark it stays that way, so there is no refresh. The host places a 9-bit X coordinate and a 9-bit Y coordinate on the inputs and raises either the set line or the clear line. The controller latches the request and drops its ready status. It then drives the selected cell for exactly one sustain period and raises ready again. A whole-panel clear is started by raising the bulk line together with its qualifier. It takes two sustain periods, after which every cell is dark.

The sustain period is a parameter counted in clock cycles. A cell-state store models the panel, and its depth is set by parameters so that a reduced grid can stand in for the full 512 x 512 one. Coordinates outside the stored grid still run a full period, but they change nothing. A separate combinational read port returns the stored state of any coordinate.

The sequencer has five states. `ST_IDLE` waits for a request. `ST_POINT` drives one cell. `ST_BULK_A` and `ST_BULK_B` are the two clear periods. `ST_DONE` reports completion and waits for the host to release its lines. The transitions are:
- IDLE to POINT on a single set or clear request.
- IDLE to BULK_A on a qualified bulk request.
- POINT to DONE, BULK_A to BULK_B, and BULK_B to DONE, each on the sustain tick.
- DONE to IDLE once the set, clear and bulk lines are all low.

Top module: `cellpanel_ctrl`

## Requirements
- R1: After reset, ready is 1, conflict_err is 0, drv_point and drv_bulk are 0, and every cell reads 0.
- R2: In IDLE, set=1 with clear=0 and no qualified bulk is accepted. Ready is 0 for exactly SUSTAIN_CYC cycles, starting on the cycle after acceptance. During that time drv_point=1, drv_set=1, and drv_x/drv_y equal the request coordinates. Afterwards the cell reads 1.
- R3: A clear request (clear=1, set=0) behaves the same way, with drv_set=0, and the cell afterwards reads 0.
- R4: A single-point operation changes only the addressed cell; every other cell keeps its state.
- R5: Bulk=1 with qualifier=1, and set and clear not both high, starts a whole-panel clear. This takes priority over a single set or clear. Ready is 0 for exactly 2*SUSTAIN_CYC cycles, drv_bulk is 1 throughout, and afterwards every cell reads 0.
- R6: Bulk=1 with qualifier=0, and set and clear both low, is ignored: ready stays 1 and no cell changes.
- R7: Set and clear high together are never accepted, even with a qualified bulk. Ready stays 1, no cell changes, and conflict_err is 1 from the next cycle. Conflict_err returns to 0 when the next request is accepted.
- R8: After completion, no new operation starts until set, clear and bulk have all been low for a cycle; a command held high keeps ready at 1.
- R9: A coordinate whose bits above the stored grid width are not all zero still occupies one full sustain period, changes no cell, and reads back 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pt_x | input | 9 | Requested X coordinate, plain binary |
| pt_y | input | 9 | Requested Y coordinate, plain binary |
| wr_req | input | 1 | Set the addressed cell |
| er_req | input | 1 | Clear the addressed cell |
| bulk_req | input | 1 | Whole-panel clear request |
| bulk_qual | input | 1 | Qualifier that must accompany bulk_req |
| ready | output | 1 | 1 when idle or complete, 0 while an operation runs |
| conflict_err | output | 1 | Set by a set-plus-clear request, cleared on the next accepted request |
| drv_point | output | 1 | Single-cell drive active |
| drv_bulk | output | 1 | Whole-panel clear drive active |
| drv_set | output | 1 | 1 for set, 0 for clear, during a point drive |
| drv_x | output | 9 | Latched X coordinate being driven |
| drv_y | output | 9 | Latched Y coordinate being driven |
| rd_x | input | 9 | Read-port X coordinate |
| rd_y | input | 9 | Read-port Y coordinate |
| rd_bit | output | 1 | Stored state of the read-port cell |

## Verification
The assertions take for granted that the host obeys the level handshake. The host holds coordinates and command lines steady from acceptance until ready returns, and it drops its lines before it issues the next request. The stimulus keeps within this because every request is driven on a falling edge and left untouched until ready is seen high. Only then are the lines released for one idle cycle. Conflicting and unqualified bulk patterns are applied only while the block is idle.

// File: rtl/cellpanel_pkg.sv
`timescale 1ns/1ps
package cellpanel_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_POINT,
        ST_BULK_A,
        ST_BULK_B,
        ST_DONE
    } seq_state_e;

endpackage

// File: rtl/cellpanel_tick.sv
`timescale 1ns/1ps
module cellpanel_tick #(
    parameter int PERIOD = 4000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    logic [CW-1:0] cnt_q;

    assign tick = run && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_TICK_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST); // R2

endmodule

// File: rtl/cellpanel_store.sv
`timescale 1ns/1ps
module cellpanel_store #(
    parameter int COORD_W = 9,
    parameter int GRID_XW = 5,
    parameter int GRID_YW = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               commit_pt,
    input  logic               commit_val,
    input  logic               commit_clr,
    input  logic [COORD_W-1:0] wx,
    input  logic [COORD_W-1:0] wy,
    input  logic [COORD_W-1:0] rx,
    input  logic [COORD_W-1:0] ry,
    output logic               rbit
);
    localparam int IW    = GRID_XW + GRID_YW;
    localparam int NCELL = 1 << IW;

    logic [NCELL-1:0] cells_q;
    logic [IW-1:0]    widx;
    logic [IW-1:0]    ridx;
    logic             w_in;
    logic             r_in;

    function automatic logic on_grid(input logic [COORD_W-1:0] cx,
                                     input logic [COORD_W-1:0] cy);
        return ((cx >> GRID_XW) == '0) && ((cy >> GRID_YW) == '0);
    endfunction

    always_comb begin
        widx = {wy[GRID_YW-1:0], wx[GRID_XW-1:0]};
        ridx = {ry[GRID_YW-1:0], rx[GRID_XW-1:0]};
        w_in = on_grid(wx, wy);
        r_in = on_grid(rx, ry);
        rbit = r_in ? cells_q[ridx] : 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cells_q <= '0;
        end else if (commit_clr) begin
            cells_q <= '0;
        end else if (commit_pt && w_in) begin
            cells_q[widx] <= commit_val;
        end
    end

    AST_ONE_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({commit_pt, commit_clr})); // R5

    AST_OTHERS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        commit_pt |=> (((cells_q ^ $past(cells_q)) & ~(NCELL'(1) << $past(widx))) == '0)); // R4

    AST_OFFGRID_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_pt && !w_in) |=> (cells_q == $past(cells_q))); // R9

endmodule

// File: rtl/cellpanel_seq.sv
`timescale 1ns/1ps
module cellpanel_seq
    import cellpanel_pkg::*;
#(
    parameter int COORD_W     = 9,
    parameter int SUSTAIN_CYC = 4000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [COORD_W-1:0] req_x,
    input  logic [COORD_W-1:0] req_y,
    input  logic               wr,
    input  logic               er,
    input  logic               bulk,
    input  logic               qual,
    input  logic               tick,
    output logic               run,
    output logic               ready,
    output logic               err,
    output logic               commit_pt,
    output logic               commit_val,
    output logic               commit_clr,
    output logic               drv_point,
    output logic               drv_bulk,
    output logic               drv_set,
    output logic [COORD_W-1:0] lat_x,
    output logic [COORD_W-1:0] lat_y
);
    localparam int BW = $clog2(2 * SUSTAIN_CYC + 1);

    seq_state_e state_q, state_d;
    logic       set_q;
    logic       err_q;
    logic       req_conf, req_bulk, req_pt, any_cmd;

    always_comb begin
        req_conf = wr && er;
        req_bulk = !req_conf && bulk && qual;
        req_pt   = !req_conf && !req_bulk && (wr || er);
        any_cmd  = wr || er || bulk;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_bulk)    state_d = ST_BULK_A;
                else if (req_pt) state_d = ST_POINT;
            end
            ST_POINT:  if (tick) state_d = ST_DONE;
            ST_BULK_A: if (tick) state_d = ST_BULK_B;
            ST_BULK_B: if (tick) state_d = ST_DONE;
            ST_DONE:   if (!any_cmd) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_x <= '0;
            lat_y <= '0;
            set_q <= 1'b0;
            err_q <= 1'b0;
        end else if (state_q == ST_IDLE) begin
            if (req_conf) begin
                err_q <= 1'b1;
            end else if (req_bulk || req_pt) begin
                err_q <= 1'b0;
                lat_x <= req_x;
                lat_y <= req_y;
                set_q <= wr;
            end
        end
    end

    always_comb begin
        ready      = 1'b0;
        run        = 1'b0;
        drv_point  = 1'b0;
        drv_bulk   = 1'b0;
        commit_pt  = 1'b0;
        commit_clr = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_DONE: ready = 1'b1;
            ST_POINT: begin
                run       = 1'b1;
                drv_point = 1'b1;
                commit_pt = tick;
            end
            ST_BULK_A: begin
                run      = 1'b1;
                drv_bulk = 1'b1;
            end
            ST_BULK_B: begin
                run        = 1'b1;
                drv_bulk   = 1'b1;
                commit_clr = tick;
            end
            default: ready = 1'b1;
        endcase
        drv_set    = drv_point && set_q;
        commit_val = set_q;
        err        = err_q;
    end

    logic [BW-1:0] busy_len_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     busy_len_q <= '0;
        else if (!ready) busy_len_q <= busy_len_q + 1'b1;
        else            busy_len_q <= '0;
    end

    AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DONE && busy_len_q != '0) |-> (busy_len_q == BW'(SUSTAIN_CYC) || busy_len_q == BW'(2 * SUSTAIN_CYC))); // R2

    AST_CONFLICT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && wr && er) |=> (ready && err)); // R7

    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DONE && any_cmd) |=> ready); // R8

    AST_DRIVE_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_point && $past(drv_point)) |-> ($stable(lat_x) && $stable(lat_y) && $stable(drv_set))); // R3

endmodule

// File: rtl/cellpanel_ctrl.sv
`timescale 1ns/1ps
module cellpanel_ctrl #(
    parameter int SUSTAIN_CYC = 4000,
    parameter int COORD_W     = 9,
    parameter int GRID_XW     = 5,
    parameter int GRID_YW     = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [COORD_W-1:0] pt_x,
    input  logic [COORD_W-1:0] pt_y,
    input  logic               wr_req,
    input  logic               er_req,
    input  logic               bulk_req,
    input  logic               bulk_qual,
    output logic               ready,
    output logic               conflict_err,
    output logic               drv_point,
    output logic               drv_bulk,
    output logic               drv_set,
    output logic [COORD_W-1:0] drv_x,
    output logic [COORD_W-1:0] drv_y,
    input  logic [COORD_W-1:0] rd_x,
    input  logic [COORD_W-1:0] rd_y,
    output logic               rd_bit
);
    logic run, tick;
    logic commit_pt, commit_val, commit_clr;

    cellpanel_tick #(.PERIOD(SUSTAIN_CYC)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .tick  (tick)
    );

    cellpanel_seq #(.COORD_W(COORD_W), .SUSTAIN_CYC(SUSTAIN_CYC)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_x      (pt_x),
        .req_y      (pt_y),
        .wr         (wr_req),
        .er         (er_req),
        .bulk       (bulk_req),
        .qual       (bulk_qual),
        .tick       (tick),
        .run        (run),
        .ready      (ready),
        .err        (conflict_err),
        .commit_pt  (commit_pt),
        .commit_val (commit_val),
        .commit_clr (commit_clr),
        .drv_point  (drv_point),
        .drv_bulk   (drv_bulk),
        .drv_set    (drv_set),
        .lat_x      (drv_x),
        .lat_y      (drv_y)
    );

    cellpanel_store #(.COORD_W(COORD_W), .GRID_XW(GRID_XW), .GRID_YW(GRID_YW)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .commit_pt  (commit_pt),
        .commit_val (commit_val),
        .commit_clr (commit_clr),
        .wx         (drv_x),
        .wy         (drv_y),
        .rx         (rd_x),
        .ry         (rd_y),
        .rbit       (rd_bit)
    );

    AST_READY_XOR_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        ready != (drv_point || drv_bulk)); // R5

endmodule

// File: tb/sim_cellpanel_ctrl.sv
`timescale 1ns/1ps
module sim_cellpanel_ctrl;
    localparam int S   = 4;
    localparam int CW  = 9;
    localparam int GXW = 4;
    localparam int GYW = 4;
    localparam int GX  = 1 << GXW;
    localparam int GY  = 1 << GYW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [CW-1:0] pt_x = '0, pt_y = '0, rd_x = '0, rd_y = '0;
    logic wr_req = 0, er_req = 0, bulk_req = 0, bulk_qual = 0;
    logic ready, conflict_err, drv_point, drv_bulk, drv_set, rd_bit;
    logic [CW-1:0] drv_x, drv_y;

    always #2.5 clk = ~clk;

    cellpanel_ctrl #(.SUSTAIN_CYC(S), .COORD_W(CW), .GRID_XW(GXW), .GRID_YW(GYW)) u0 (
        .clk(clk), .rst_n(rst_n), .pt_x(pt_x), .pt_y(pt_y),
        .wr_req(wr_req), .er_req(er_req), .bulk_req(bulk_req), .bulk_qual(bulk_qual),
        .ready(ready), .conflict_err(conflict_err), .drv_point(drv_point),
        .drv_bulk(drv_bulk), .drv_set(drv_set), .drv_x(drv_x), .drv_y(drv_y),
        .rd_x(rd_x), .rd_y(rd_y), .rd_bit(rd_bit)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit model [GX*GY];

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic bit on_grid(input int x, input int y);
        return (x < GX) && (y < GY);
    endfunction

    function automatic bit exp_cell(input int x, input int y);
        return on_grid(x, y) ? model[y*GX + x] : 1'b0;
    endfunction

    task automatic peek(input int x, input int y, output bit v);
        rd_x = CW'(x);
        rd_y = CW'(y);
        #0.2;
        v = rd_bit;
    endtask

    task automatic full_scan(input string tag);
        int bad = 0;
        bit v;
        for (int y = 0; y < GY; y++) begin
            for (int x = 0; x < GX; x++) begin
                peek(x, y, v);
                if (v != model[y*GX + x]) bad++;
            end
        end
        chk(bad == 0, tag, bad, 0);
    endtask

    // kind: 0 set, 1 clear, 2 bulk
    task automatic do_op(input int kind, input int x, input int y, input string tag);
        int n = 0;
        int exp_len;
        bit v;
        @(negedge clk);
        pt_x = CW'(x); pt_y = CW'(y);
        wr_req = (kind == 0); er_req = (kind == 1);
        bulk_req = (kind == 2); bulk_qual = (kind == 2);
        @(negedge clk);
        while (!ready && n < 1000) begin
            if (n == 0) begin
                if (kind == 2) chk(drv_bulk == 1'b1 && drv_point == 1'b0, {tag, " bulk drive"}, int'(drv_bulk), 1);
                else begin
                    chk(drv_point && drv_x == CW'(x) && drv_y == CW'(y), {tag, " drive coords"}, int'(drv_x), x);
                    chk(drv_set == (kind == 0), {tag, " drive polarity"}, int'(drv_set), int'(kind == 0));
                end
            end
            n++;
            @(negedge clk);
        end
        exp_len = (kind == 2) ? 2 * S : S;
        chk(n == exp_len, {tag, " busy length"}, n, exp_len);
        if (kind == 2) begin
            for (int i = 0; i < GX*GY; i++) model[i] = 1'b0;
        end else if (on_grid(x, y)) begin
            model[y*GX + x] = (kind == 0);
        end
        if (kind != 2) begin
            peek(x, y, v);
            chk(v == exp_cell(x, y), {tag, " cell readback"}, int'(v), int'(exp_cell(x, y)));
        end
        wr_req = 0; er_req = 0; bulk_req = 0; bulk_qual = 0;
        @(negedge clk);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(5.0 * 200000);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        summary();
    end

    initial begin
        bit v;
        int kind, x, y, r;
        void'($urandom(32'd20240611));
        for (int i = 0; i < GX*GY; i++) model[i] = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(ready == 1 && conflict_err == 0, "R1 status after reset", int'(ready), 1);
        chk(drv_point == 0 && drv_bulk == 0, "R1 drives idle", int'(drv_point | drv_bulk), 0);
        full_scan("R1 cells clear");

        // R2 / R3 / R4 selective set and clear
        do_op(0, 3, 5, "R2");
        do_op(0, 4, 5, "R2");
        do_op(0, 15, 15, "R2");
        do_op(1, 3, 5, "R3");
        full_scan("R4 neighbours kept");

        // R6 unqualified bulk ignored
        @(negedge clk);
        bulk_req = 1; bulk_qual = 0;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            chk(ready == 1, "R6 unqualified bulk ready", int'(ready), 1);
        end
        bulk_req = 0;
        @(negedge clk);
        full_scan("R6 cells unchanged");

        // R7 conflicting set and clear, also with qualified bulk
        pt_x = 9'd7; pt_y = 9'd7;
        wr_req = 1; er_req = 1; bulk_req = 1; bulk_qual = 1;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(ready == 1, "R7 conflict not accepted", int'(ready), 1);
            chk(conflict_err == 1, "R7 conflict flag", int'(conflict_err), 1);
        end
        wr_req = 0; er_req = 0; bulk_req = 0; bulk_qual = 0;
        @(negedge clk);
        full_scan("R7 cells unchanged");
        chk(conflict_err == 1, "R7 flag persists", int'(conflict_err), 1);
        @(negedge clk);
        pt_x = 9'd1; pt_y = 9'd2; wr_req = 1;
        @(negedge clk);
        chk(conflict_err == 0, "R7 flag cleared on accept", int'(conflict_err), 0);
        while (!ready) @(negedge clk);
        model[2*GX + 1] = 1'b1;

        // R8 held command after completion does not restart
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            chk(ready == 1 && drv_point == 0, "R8 held command no restart", int'(ready), 1);
        end
        wr_req = 0;
        @(negedge clk);
        full_scan("R8 cells");

        // R9 off-grid coordinates
        do_op(0, 300, 2, "R9");
        do_op(0, 1, 17, "R9");
        peek(300, 2, v);
        chk(v == 0, "R9 off-grid read", int'(v), 0);
        full_scan("R9 cells unchanged");

        // R5 bulk clear, also with set present
        @(negedge clk);
        pt_x = 9'd5; pt_y = 9'd5;
        wr_req = 1; bulk_req = 1; bulk_qual = 1;
        @(negedge clk);
        chk(drv_bulk == 1 && drv_point == 0, "R5 bulk priority", int'(drv_bulk), 1);
        r = 0;
        while (!ready && r < 1000) begin r++; @(negedge clk); end
        chk(r == 2 * S, "R5 bulk length", r, 2 * S);
        for (int i = 0; i < GX*GY; i++) model[i] = 1'b0;
        wr_req = 0; bulk_req = 0; bulk_qual = 0;
        @(negedge clk);
        full_scan("R5 panel cleared");

        // random mix
        for (int i = 0; i < 80; i++) begin
            r = $urandom_range(0, 99);
            kind = (r < 46) ? 0 : (r < 92) ? 1 : 2;
            if ($urandom_range(0, 99) < 85) begin
                x = $urandom_range(0, GX - 1);
                y = $urandom_range(0, GY - 1);
            end else begin
                x = $urandom_range(0, 511);
                y = $urandom_range(0, 511);
            end
            if (kind == 0)      do_op(0, x, y, "R2 random");
            else if (kind == 1) do_op(1, x, y, "R3 random");
            else                do_op(2, 0, 0, "R5 random");
            if (i % 10 == 9) full_scan("R4 random scan");
        end
        full_scan("R4 final scan");

        summary();
    end

endmodule